// File: doc/BRIEF.md
# Servo-Link Serial Frame Transmitter

This block turns six signed servo channel values, an 8-bit model identifier and a few mode controls into a 14-byte link frame, then shifts the frame out on one asynchronous serial line. A host pulses a frame-start strobe about every 22 ms. On the strobe the block samples all of its inputs and scales and packs them into bytes. It then sends the bytes back to back: each byte is one start bit, eight data bits least significant bit first, and two stop bits. Every bit lasts a fixed number of clock cycles, which sets the baud rate. At 125 MHz the default of 1000 cycles per bit gives 125000 baud.

The first byte is the header. It holds a code for the link variant and the bind or range-check flag. The second byte is the model identifier. Each channel then takes two bytes. The first of the pair carries the channel's own index above the top two bits of a 10-bit position. The second carries the low eight position bits.

A bind request is honoured only during a short window after reset. The window is a count of frames and is set by a parameter.

Top module: `rc_link_tx`

## Requirements
- R1: After reset, and whenever no frame is in flight, `tx_line` is 1 and `tx_busy` is 0.
- R2: The frame is 14 bytes. Each byte is 11 slots sent with no gap between slots or bytes: slot 0 is 0 (start), slots 1 to 8 are data bits 0 to 7, and slots 9 and 10 are 1 (stop). Each slot lasts TICKS_PER_BIT cycles. `tx_busy` is 1 for exactly 154*TICKS_PER_BIT cycles, from the start slot of byte 0 to the end of the last stop slot.
- R3: Bits 4 and 3 of header byte 0 encode the link variant: `link_sel` 0 gives 0x00, 1 gives 0x10, and 2 or 3 give 0x18.
- R4: Header bit 7 (0x80) is set when bind is requested and permitted. Otherwise header bit 5 (0x20) is set when `range_req` is 1. Bind takes priority, so the two bits are never both set.
- R5: A bind request is permitted only in the first BIND_FRAMES frames sent after reset. Every started frame uses up one permit, whether or not bind was requested.
- R6: Byte 1 equals `model_id`.
- R7: For channel i (0 to 5), byte 2+2i is {i[5:0], pos[9:8]} and byte 3+2i is pos[7:0].
- R8: pos = clamp(floor(v*13/32) + 512, 0, 1023), where v is the signed 11-bit value on `ch_val[i*11 +: 11]`.
- R9: All frame contents are sampled at the cycle the strobe is accepted. Input changes after that do not alter the frame in flight.
- R10: A strobe that arrives while `tx_busy` is 1 is ignored. It does not restart the frame, does not queue another frame and does not use up a bind permit. A strobe held high starts the next frame in the cycle after the previous frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_go | input | 1 | Frame-start strobe, accepted when idle |
| ch_val | input | 66 | Six signed 11-bit channel values, channel i at bits [i*11 +: 11] |
| model_id | input | 8 | Model identifier sent in byte 1 |
| link_sel | input | 2 | Link variant select |
| bind_req | input | 1 | Bind request |
| range_req | input | 1 | Range-check request |
| tx_line | output | 1 | Serial output, idles high |
| tx_busy | output | 1 | High while a frame is being sent |

## Verification
The hardest case to reach from the ports is the end of the bind window. The bench must send exactly BIND_FRAMES frames with bind asserted, then check that the next frame falls back to the range flag. The bench builds the BIND_FRAMES=2 instance and sends frames with both requests high, in order. A second hard case is a strobe, together with input changes, that lands in the middle of a frame. The bench applies both partway through a frame and checks that the rest of the waveform is unchanged. It then holds the strobe high across a frame boundary to check that the next frame starts with no gap.

// File: rtl/rc_link_pkg.sv
package rc_link_pkg;

    localparam int BYTE_W        = 8;
    localparam int POS_W         = 10;
    localparam int SLOTS_PER_BYTE = 11;

    localparam logic [7:0] FLAG_BIND  = 8'h80;
    localparam logic [7:0] FLAG_RANGE = 8'h20;

    function automatic logic [7:0] variant_code(input logic [1:0] sel);
        case (sel)
            2'd0:    return 8'h00;
            2'd1:    return 8'h10;
            default: return 8'h18;
        endcase
    endfunction

endpackage

// File: rtl/rc_chan_scale.sv
module rc_chan_scale #(
    parameter int CH_W = 11
) (
    input  logic [CH_W-1:0] val,
    output logic [9:0]      pos
);
    localparam int W = CH_W + 6;
    localparam logic signed [W-1:0] GAIN = W'(13);
    localparam logic signed [W-1:0] BIAS = W'(512);
    localparam logic signed [W-1:0] PMAX = W'(1023);

    logic signed [W-1:0] ext, prod, biased;

    always_comb begin
        ext    = {{6{val[CH_W-1]}}, val};
        prod   = ext * GAIN;
        biased = (prod >>> 5) + BIAS;
        if (biased < 0)
            pos = '0;
        else if (biased > PMAX)
            pos = 10'd1023;
        else
            pos = biased[9:0];
    end
endmodule

// File: rtl/rc_frame_pack.sv
module rc_frame_pack
    import rc_link_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int CH_W   = 11,
    localparam int NBYTES = 2 + 2 * NUM_CH
) (
    input  logic [NUM_CH*CH_W-1:0]   ch_val,
    input  logic [7:0]               model_id,
    input  logic [1:0]               link_sel,
    input  logic                     bind_req,
    input  logic                     range_req,
    input  logic                     bind_ok,
    output logic [NBYTES-1:0][7:0]   frame
);
    logic [NUM_CH-1:0][9:0] pos;

    always_comb begin
        frame[0] = variant_code(link_sel);
        if (bind_req && bind_ok)
            frame[0] = frame[0] | FLAG_BIND;
        else if (range_req)
            frame[0] = frame[0] | FLAG_RANGE;
        frame[1] = model_id;
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        rc_chan_scale #(.CH_W(CH_W)) u_scale (
            .val (ch_val[i*CH_W +: CH_W]),
            .pos (pos[i])
        );
        assign frame[2+2*i] = {6'(i), pos[i][9:8]};
        assign frame[3+2*i] = pos[i][7:0];
    end
endmodule

// File: rtl/rc_serial_shift.sv
module rc_serial_shift
    import rc_link_pkg::*;
#(
    parameter int NBYTES        = 14,
    parameter int TICKS_PER_BIT = 1000
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [NBYTES-1:0][7:0]  frame_in,
    output logic                    accept,
    output logic                    tx,
    output logic                    busy
);
    localparam int TW  = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
    localparam int BYW = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam logic [TW-1:0]  TICK_LAST = TW'(TICKS_PER_BIT - 1);
    localparam logic [3:0]     SLOT_LAST = 4'(SLOTS_PER_BYTE - 1);
    localparam logic [BYW-1:0] BYTE_LAST = BYW'(NBYTES - 1);

    typedef struct packed {
        logic                   busy;
        logic                   line;
        logic [TW-1:0]          tick;
        logic [3:0]             slot;
        logic [BYW-1:0]         idx;
        logic [NBYTES-1:0][7:0] frame;
    } sh_t;

    sh_t s_d, s_q;

    function automatic logic slot_level(input logic [3:0] slot, input logic [7:0] b);
        if (slot == 4'd0)
            return 1'b0;
        else if (slot <= 4'd8)
            return b[3'(slot - 4'd1)];
        else
            return 1'b1;
    endfunction

    always_comb begin
        s_d    = s_q;
        accept = 1'b0;
        if (!s_q.busy) begin
            if (start) begin
                accept     = 1'b1;
                s_d.busy   = 1'b1;
                s_d.frame  = frame_in;
                s_d.tick   = '0;
                s_d.slot   = '0;
                s_d.idx    = '0;
            end
        end else if (s_q.tick == TICK_LAST) begin
            s_d.tick = '0;
            if (s_q.slot == SLOT_LAST) begin
                s_d.slot = '0;
                if (s_q.idx == BYTE_LAST)
                    s_d.busy = 1'b0;
                else
                    s_d.idx = s_q.idx + 1'b1;
            end else begin
                s_d.slot = s_q.slot + 4'd1;
            end
        end else begin
            s_d.tick = s_q.tick + 1'b1;
        end
        s_d.line = s_d.busy ? slot_level(s_d.slot, s_d.frame[s_d.idx]) : 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q      <= '0;
            s_q.line <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign tx   = s_q.line;
    assign busy = s_q.busy;

    assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> tx);

    assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !tx);

    assert_full_frame_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(s_q.idx) == BYTE_LAST && $past(s_q.slot) == SLOT_LAST));

    assert_frame_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(s_q.frame));
endmodule

// File: rtl/rc_link_tx.sv
module rc_link_tx #(
    parameter int NUM_CH        = 6,
    parameter int CH_W          = 11,
    parameter int TICKS_PER_BIT = 1000,
    parameter int BIND_FRAMES   = 250
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   frame_go,
    input  logic [NUM_CH*CH_W-1:0] ch_val,
    input  logic [7:0]             model_id,
    input  logic [1:0]             link_sel,
    input  logic                   bind_req,
    input  logic                   range_req,
    output logic                   tx_line,
    output logic                   tx_busy
);
    localparam int NBYTES = 2 + 2 * NUM_CH;
    localparam int PW     = $clog2(BIND_FRAMES + 1);
    localparam logic [PW-1:0] PERMIT_INIT = PW'(BIND_FRAMES);

    typedef struct packed {
        logic [PW-1:0] permits;
    } top_t;

    top_t t_d, t_q;
    logic                   accept;
    logic                   bind_ok;
    logic [NBYTES-1:0][7:0] frame;

    assign bind_ok = (t_q.permits != '0);

    always_comb begin
        t_d = t_q;
        if (accept && bind_ok)
            t_d.permits = t_q.permits - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            t_q.permits <= PERMIT_INIT;
        else
            t_q <= t_d;
    end

    rc_frame_pack #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pack (
        .ch_val    (ch_val),
        .model_id  (model_id),
        .link_sel  (link_sel),
        .bind_req  (bind_req),
        .range_req (range_req),
        .bind_ok   (bind_ok),
        .frame     (frame)
    );

    rc_serial_shift #(.NBYTES(NBYTES), .TICKS_PER_BIT(TICKS_PER_BIT)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .start    (frame_go),
        .frame_in (frame),
        .accept   (accept),
        .tx       (tx_line),
        .busy     (tx_busy)
    );

    assert_permit_spent_R5: assert property (@(posedge clk) disable iff (rst)
        (accept && t_q.permits != '0) |=> (t_q.permits == $past(t_q.permits) - 1'b1));

    assert_permit_closed_R5: assert property (@(posedge clk) disable iff (rst)
        (t_q.permits == '0) |=> (t_q.permits == '0));

    assert_busy_ignores_go_R10: assert property (@(posedge clk) disable iff (rst)
        (tx_busy && frame_go) |=> $stable(t_q.permits));
endmodule

// File: tb/tb_rc_link_tx.sv
module tb_rc_link_tx;
    localparam int TPB   = 4;
    localparam int BINDN = 2;
    localparam int NCH   = 6;
    localparam int CW    = 11;

    logic clk = 1'b0;
    logic rst;
    logic frame_go;
    logic [NCH*CW-1:0] ch_val;
    logic [7:0] model_id;
    logic [1:0] link_sel;
    logic bind_req, range_req;
    logic tx_line, tx_busy;

    always #4 clk = ~clk;

    rc_link_tx #(.NUM_CH(NCH), .CH_W(CW), .TICKS_PER_BIT(TPB), .BIND_FRAMES(BINDN)) dut (
        .clk(clk), .rst(rst), .frame_go(frame_go), .ch_val(ch_val),
        .model_id(model_id), .link_sel(link_sel), .bind_req(bind_req),
        .range_req(range_req), .tx_line(tx_line), .tx_busy(tx_busy)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;
    bit    live   = 1'b0;
    string tag    = "R1";
    bit    slots[$];
    int    permits;

    function automatic int scale_pos(input int v);
        int p;
        p = ((v * 13) >>> 5) + 512;
        if (p < 0) p = 0;
        if (p > 1023) p = 1023;
        return p;
    endfunction

    function automatic void push_frame();
        int bytes[14];
        int v, p;
        bytes[0] = (link_sel == 2'd0) ? 8'h00 : (link_sel == 2'd1) ? 8'h10 : 8'h18;
        if (bind_req && permits > 0) bytes[0] |= 8'h80;
        else if (range_req)          bytes[0] |= 8'h20;
        if (permits > 0) permits--;
        bytes[1] = model_id;
        for (int i = 0; i < NCH; i++) begin
            v = $signed(ch_val[i*CW +: CW]);
            p = scale_pos(v);
            bytes[2+2*i] = ((i << 2) | (p >> 8)) & 8'hFF;
            bytes[3+2*i] = p & 8'hFF;
        end
        for (int b = 0; b < 14; b++)
            for (int s = 0; s < 11; s++)
                for (int t = 0; t < TPB; t++)
                    slots.push_back(s == 0 ? 1'b0 : (s <= 8 ? bytes[b][s-1] : 1'b1));
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            slots.delete();
            permits = BINDN;
        end else begin
            bit was_busy;
            was_busy = (slots.size() > 0);
            if (was_busy) void'(slots.pop_front());
            if (!was_busy && frame_go) push_frame();
        end
    end

    always @(negedge clk) begin
        if (live && !done) begin
            bit eb, et;
            eb = (slots.size() > 0);
            et = eb ? slots[0] : 1'b1;
            checks++;
            if (tx_line !== et || tx_busy !== eb) begin
                fails++;
                $display("FAIL %s: tx=%0b busy=%0b expected tx=%0b busy=%0b", tag, tx_line, tx_busy, et, eb);
            end
        end
    end

    task automatic set_ch(input int a, input int b, input int c, input int d, input int e, input int f);
        ch_val = {CW'(f), CW'(e), CW'(d), CW'(c), CW'(b), CW'(a)};
    endtask

    task automatic send_frame();
        frame_go = 1'b1;
        @(negedge clk);
        frame_go = 1'b0;
        while (tx_busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; frame_go = 1'b0; model_id = 8'h00; link_sel = 2'd0;
        bind_req = 1'b0; range_req = 1'b0; set_ch(0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        checks++;
        if (tx_line !== 1'b1 || tx_busy !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: tx=%0b busy=%0b expected tx=1 busy=0", tx_line, tx_busy);
        end
        rst = 1'b0;
        live = 1'b1;
        repeat (4) @(negedge clk);

        // R3 R4 R5 R6 R7 R8: variant 0, bind inside window, extreme values
        tag = "R2/R3/R4/R5/R6/R7/R8 frame1";
        link_sel = 2'd0; model_id = 8'hA5; bind_req = 1'b1;
        set_ch(-1024, 1023, 0, -1, 100, -37);
        send_frame();

        // R4: bind wins over range while still permitted
        tag = "R4/R5 frame2 bind priority";
        link_sel = 2'd1; model_id = 8'h3C; range_req = 1'b1;
        set_ch(500, -500, 31, -32, 1, 2);
        send_frame();

        // R5: window exhausted, range flag instead
        tag = "R5/R4 frame3 window closed";
        link_sel = 2'd2; model_id = 8'hFF;
        set_ch(-2, 33, -33, 700, -700, 12);
        send_frame();

        // R3: variant 3 with no flags
        tag = "R3/R6 frame4 variant3";
        link_sel = 2'd3; bind_req = 1'b0; range_req = 1'b0; model_id = 8'h01;
        set_ch(7, -7, 64, -64, 255, -256);
        send_frame();

        // R9 R10: change inputs and re-strobe mid-frame
        tag = "R9/R10 frame5 mid-frame changes";
        link_sel = 2'd1; model_id = 8'h5A;
        set_ch(10, 20, 30, 40, 50, 60);
        frame_go = 1'b1;
        @(negedge clk);
        frame_go = 1'b0;
        repeat (150) @(negedge clk);
        set_ch(-900, 900, -5, 5, 0, 0);
        model_id = 8'h99; link_sel = 2'd2; bind_req = 1'b1; range_req = 1'b1;
        frame_go = 1'b1;
        @(negedge clk);
        frame_go = 1'b0;
        while (tx_busy) @(negedge clk);
        repeat (3) @(negedge clk);

        // R10: strobe held high across a frame boundary
        tag = "R10/R2 frames6-7 back-to-back";
        bind_req = 1'b0; range_req = 1'b0; link_sel = 2'd0;
        set_ch(111, -111, 222, -222, 333, -333);
        frame_go = 1'b1;
        @(negedge clk);
        set_ch(-1000, 1000, 3, -3, 9, -9);
        model_id = 8'h7E;
        while (tx_busy) @(negedge clk);
        @(negedge clk);
        frame_go = 1'b0;
        while (tx_busy) @(negedge clk);
        repeat (5) @(negedge clk);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end
endmodule